// File: doc/BRIEF.md
# Serial Scan Shift Engine

This block moves a bit vector serially into a test access port while collecting the bits that come back. Software-side logic or a sequencer first fills an internal byte buffer through a simple write port. It then gives a start strobe with a bit count and an exit flag. The engine generates the test clock and clocks the data out of the buffer on the data-in line. It records each bit from the data-out line into a second byte buffer, which is read back through a combinational read port. The engine assumes the TAP is already in a shift state. Moving the TAP to that state is the job of a separate sequencer.

Bits go out in ascending order: bit 0 of byte 0 first. Long transfers are split into chunks of `CHUNK_BITS` bits. Between chunks the test clock rests low for `GAP_CYCLES` system clock cycles, and the mode-select line stays low, so the TAP never leaves the shift state. When the exit flag is set, the mode-select line is raised on the final bit of the whole transfer. A companion status pulse then tells a state tracker that the TAP has moved to its Exit1 state. A wait mode reuses the same timing to issue a number of idle clock pulses, with mode-select and data-in both held low and nothing recorded.

Top module: `jscan_engine`

## Requirements
- R1: After reset, `tck`, `tms`, `tdi`, `busy`, `done` and `exitReached` are 0, and every byte of the capture buffer reads 0.
- R2: For a transfer of N bits, `tck` rises exactly N times. At rising edge k (k from 0), `tdi` equals bit k%8 of input buffer byte k/8, so the least-significant bit goes first and bytes go in ascending order.
- R3: When N is not a multiple of 8, only the low N%8 bits of the last byte are shifted, and no further `tck` rise occurs.
- R4: The `tdo` value present at rising edge k is written to capture buffer byte k/8, bit k%8. Capture bits at positions N and above keep their previous values.
- R5: `tms` is 0 at every rising edge, except the last rising edge of a transfer whose `mustEnd` was 1 at start. There it is 1.
- R6: `exitReached` is 1 only in the `done` cycle, and only when `mustEnd` was set, wait mode was off and N > 0.
- R7: After each full chunk of `CHUNK_BITS` (256) bits that is not the last, `tck` and `tms` stay low for `GAP_CYCLES` (2) extra cycles. `done` is seen 2N + GAP_CYCLES*(ceil(N/256)-1) + 1 cycles after the clock edge that samples `start`.
- R8: `tdi` changes only while `tck` is low: its value during each high phase equals its value in the low phase just before.
- R9: A start with N = 0 raises `done` one cycle after `start` is sampled, and `tck` does not rise.
- R10: In wait mode, `tck` rises N times with `tms` = 0 and `tdi` = 0, the capture buffer is left unchanged, and `exitReached` stays 0.
- R11: `done` lasts one cycle, and `busy` is 1 from the cycle after `start` until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| bitCount | input | CNT_W | Number of bits or idle pulses |
| mustEnd | input | 1 | Raise TMS on the final bit |
| waitMode | input | 1 | Issue idle pulses instead of data |
| wrEn | input | 1 | Write strobe for the input buffer |
| wrAddr | input | AW | Input buffer byte address |
| wrData | input | 8 | Input buffer byte |
| rdAddr | input | AW | Capture buffer byte address |
| rdData | output | 8 | Capture buffer byte (combinational) |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to the target |
| tdo | input | 1 | Serial data from the target |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| exitReached | output | 1 | TAP moved to Exit1 with this completion |

## Verification
A wrong bit index or byte select shows up at the first rising test-clock edge as a wrong `tdi` value, or later as a displaced bit in the capture buffer. A wrong chunk counter or gap counter changes when `done` arrives, so the completion latency is checked against the formula for 1, 2 and 3 chunks. An exit flag applied at the wrong point shows as `tms` high on an earlier bit, or as a missing `exitReached` in the `done` cycle. Wait mode is checked by confirming that the capture buffer is unchanged afterwards.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_HIGH,
    S_GAP,
    S_DONE
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic drive;    // present buffer bit on tdi
    logic capture;  // store tdo at the coming rising tck
  } scanStrobe_t;

endpackage

// File: rtl/jscan_ctrl.sv
module jscan_ctrl
  import jscan_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int CHUNK_BITS = 256,
  parameter int GAP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             mustEnd,
  input  logic             waitMode,
  output scanStrobe_t      stb,
  output logic [CNT_W-1:0] bitIdx,
  output logic             tck,
  output logic             tms,
  output logic             busy,
  output logic             done,
  output logic             exitReached
);

  localparam int CH_W  = $clog2(CHUNK_BITS + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  scanState_t       state;
  logic [CNT_W-1:0] total;
  logic [CH_W-1:0]  chunkLeft;
  logic [GAP_W-1:0] gapCnt;
  logic             mustEndR;
  logic             waitR;

  logic [CNT_W-1:0] remAfter;
  logic [CH_W-1:0]  firstChunk;
  logic [CH_W-1:0]  nextChunk;
  logic             lastBit;
  logic             inBit;

  always_comb begin
    remAfter   = total - bitIdx - CNT_W'(1);
    firstChunk = (bitCount > CNT_W'(CHUNK_BITS)) ? CH_W'(CHUNK_BITS) : CH_W'(bitCount);
    nextChunk  = (remAfter > CNT_W'(CHUNK_BITS)) ? CH_W'(CHUNK_BITS) : CH_W'(remAfter);
    lastBit    = (bitIdx == total - CNT_W'(1));
    inBit      = (state == S_LOW) || (state == S_HIGH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      total     <= '0;
      bitIdx    <= '0;
      chunkLeft <= '0;
      gapCnt    <= '0;
      mustEndR  <= 1'b0;
      waitR     <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          total     <= bitCount;
          mustEndR  <= mustEnd;
          waitR     <= waitMode;
          bitIdx    <= '0;
          chunkLeft <= firstChunk;
          state     <= (bitCount == '0) ? S_DONE : S_LOW;
        end
        S_LOW:  state <= S_HIGH;
        S_HIGH: begin
          bitIdx <= bitIdx + CNT_W'(1);
          if (lastBit) begin
            state <= S_DONE;
          end else if (chunkLeft == CH_W'(1)) begin
            chunkLeft <= nextChunk;
            gapCnt    <= GAP_W'(GAP_CYCLES - 1);
            state     <= S_GAP;
          end else begin
            chunkLeft <= chunkLeft - CH_W'(1);
            state     <= S_LOW;
          end
        end
        S_GAP: begin
          if (gapCnt == '0) state <= S_LOW;
          else              gapCnt <= gapCnt - GAP_W'(1);
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    tck         = (state == S_HIGH);
    tms         = inBit && mustEndR && !waitR && lastBit;
    stb.drive   = inBit && !waitR;
    stb.capture = (state == S_LOW) && !waitR;
    busy        = (state != S_IDLE);
    done        = (state == S_DONE);
    exitReached = done && mustEndR && !waitR && (total != '0);
  end

  // R11
  tck_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tck |=> !tck);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  exit_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    exitReached |-> done);

  // R5
  tms_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tck && tms) |=> done);

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && bitCount == '0) |=> (done && !tck));

  // R7
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP) |-> (!tck && !tms));

endmodule

// File: rtl/jscan_dpath.sv
module jscan_dpath
  import jscan_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int CNT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  scanStrobe_t                  stb,
  input  logic [CNT_W-1:0]             bitIdx,
  input  logic                         wrEn,
  input  logic [$clog2(MAX_BYTES)-1:0] wrAddr,
  input  logic [7:0]                   wrData,
  input  logic [$clog2(MAX_BYTES)-1:0] rdAddr,
  output logic [7:0]                   rdData,
  input  logic                         tdo,
  output logic                         tdi
);

  localparam int AW   = $clog2(MAX_BYTES);
  localparam int BITS = MAX_BYTES * 8;
  localparam int BW   = $clog2(BITS);

  logic [7:0] inBuf  [MAX_BYTES];
  logic [7:0] outBuf [MAX_BYTES];

  logic [AW-1:0] byteSel;
  logic [2:0]    bitSel;

  always_comb begin
    byteSel = bitIdx[BW-1:3];
    bitSel  = bitIdx[2:0];
    tdi     = stb.drive & inBuf[byteSel][bitSel];
    rdData  = outBuf[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_BYTES; i++) begin
        inBuf[i]  <= '0;
        outBuf[i] <= '0;
      end
    end else begin
      if (wrEn) inBuf[wrAddr] <= wrData;
      if (stb.capture) outBuf[byteSel][bitSel] <= tdo;
    end
  end

  // R4
  capture_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (bitIdx < CNT_W'(BITS)));

  // R8
  tdi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !wrEn) |=> $stable(tdi));

endmodule

// File: rtl/jscan_engine.sv
module jscan_engine
  import jscan_pkg::*;
#(
  parameter int MAX_BYTES  = 64,
  parameter int CNT_W      = 16,
  parameter int CHUNK_BITS = 256,
  parameter int GAP_CYCLES = 2,
  localparam int AW        = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             mustEnd,
  input  logic             waitMode,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [7:0]       wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [7:0]       rdData,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo,
  output logic             busy,
  output logic             done,
  output logic             exitReached
);

  scanStrobe_t      stb;
  logic [CNT_W-1:0] bitIdx;

  jscan_ctrl #(
    .CNT_W(CNT_W), .CHUNK_BITS(CHUNK_BITS), .GAP_CYCLES(GAP_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .bitCount(bitCount),
    .mustEnd(mustEnd), .waitMode(waitMode), .stb(stb), .bitIdx(bitIdx),
    .tck(tck), .tms(tms), .busy(busy), .done(done), .exitReached(exitReached)
  );

  jscan_dpath #(
    .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIdx(bitIdx),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tdo(tdo), .tdi(tdi)
  );

endmodule

// File: tb/tb_jscan_engine.sv
module tb_jscan_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 64;
  localparam int AW         = 6;

  typedef struct packed {
    int unsigned cnt;
    bit          endFlag;
    bit          waitFlag;
    int unsigned seed;
    int unsigned expLat;
    bit          expExit;
  } vec_t;

  // cnt, mustEnd, wait, seed, expected done latency, expected exit
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8,   1'b0, 1'b0, 1, 17,   1'b0},
    '{13,  1'b1, 1'b0, 2, 27,   1'b1},
    '{1,   1'b1, 1'b0, 3, 3,    1'b1},
    '{300, 1'b1, 1'b0, 4, 603,  1'b1},
    '{256, 1'b0, 1'b0, 5, 513,  1'b0},
    '{512, 1'b1, 1'b0, 6, 1027, 1'b1},
    '{40,  1'b0, 1'b1, 7, 81,   1'b0},
    '{600, 1'b1, 1'b1, 8, 1205, 1'b0},
    '{0,   1'b1, 1'b0, 9, 1,    1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] bitCount = '0;
  logic mustEnd = 1'b0, waitMode = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic tck, tms, tdi, tdo, busy, done, exitReached;

  int nChecks = 0, nFail = 0;
  int riseCnt = 0, riseBase = 0, negCnt = 0, negBase = 0, edgeErr = 0;
  int curSeed = 0;
  bit prevTck = 1'b0, lowTdi = 1'b0;
  bit [1023:0] recTdi, recTms;
  logic [7:0] prevOut [NBYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  jscan_engine dut (
    .clk(clk), .rstN(rstN), .start(start), .bitCount(bitCount),
    .mustEnd(mustEnd), .waitMode(waitMode), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo), .busy(busy), .done(done), .exitReached(exitReached)
  );

  function automatic bit tgtBit(int k, int seed);
    return bit'((((k * 7 + seed * 3) >> 2) & 1) ^ ((k % 3) == 0 ? 1 : 0));
  endfunction

  function automatic logic [7:0] inByte(int i, int seed);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction

  // target model: tdo advances after each falling tck
  assign tdo = tgtBit(negCnt - negBase, curSeed);

  always @(negedge clk) begin
    if (tck === 1'b1) begin
      int ri;
      ri = riseCnt - riseBase;
      if (ri >= 0 && ri < 1024) begin
        recTdi[ri] = tdi;
        recTms[ri] = tms;
      end
      riseCnt++;
      if (tdi !== lowTdi) edgeErr++;
    end else begin
      lowTdi = tdi;
    end
    if (prevTck && tck === 1'b0) negCnt++;
    prevTck = (tck === 1'b1);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic readByte(int a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = AW'(a);
    #1 v = rdData;
  endtask

  task automatic runVec(vec_t v);
    int cyc, errs, firstErr, expBusy, dummy;
    bit sawExit, busyOk;
    logic [7:0] b;
    // load input buffer and snapshot capture buffer
    for (int i = 0; i < NBYTES; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = AW'(i); wrData = inByte(i, int'(v.seed));
    end
    @(negedge clk);
    wrEn = 1'b0;
    for (int i = 0; i < NBYTES; i++) readByte(i, prevOut[i]);
    recTdi = '0; recTms = '0;
    riseBase = riseCnt; negBase = negCnt; curSeed = int'(v.seed);
    edgeErr = 0;
    @(negedge clk);
    start = 1'b1; bitCount = 16'(v.cnt); mustEnd = v.endFlag; waitMode = v.waitFlag;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    busyOk = (busy === 1'b1);
    while (done !== 1'b1 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (done !== 1'b1 && busy !== 1'b1) busyOk = 1'b0;
    end
    sawExit = (exitReached === 1'b1);
    // R7 / R9 latency
    chk(cyc == int'(v.expLat), "R7", "done latency", cyc, v.expLat);
    chk(busyOk, "R11", "busy until done", busyOk, 1);
    chk(sawExit == v.expExit, "R6", "exitReached", sawExit, v.expExit);
    @(negedge clk);
    chk(done === 1'b0, "R11", "done single cycle", done, 0);
    chk(riseCnt - riseBase == int'(v.cnt), v.waitFlag ? "R10" : "R2", "tck rises",
        riseCnt - riseBase, v.cnt);
    chk(edgeErr == 0, "R8", "tdi moved while tck high", edgeErr, 0);
    // tdi and tms per bit
    errs = 0; firstErr = -1;
    for (int k = 0; k < int'(v.cnt) && k < 1024; k++) begin
      bit expD, expM;
      b = inByte(k / 8, int'(v.seed));
      expD = v.waitFlag ? 1'b0 : b[k % 8];
      expM = v.endFlag && !v.waitFlag && (k == int'(v.cnt) - 1);
      if (recTdi[k] != expD || recTms[k] != expM) begin
        errs++;
        if (firstErr < 0) firstErr = k;
      end
    end
    chk(errs == 0, v.waitFlag ? "R10" : "R5", "tdi/tms bit mismatches (R2 R3)", errs, 0);
    // capture buffer
    errs = 0;
    for (int i = 0; i < NBYTES; i++) begin
      logic [7:0] expB;
      readByte(i, b);
      for (int j = 0; j < 8; j++) begin
        int k;
        k = i * 8 + j;
        expB[j] = (!v.waitFlag && k < int'(v.cnt)) ? tgtBit(k, int'(v.seed)) : prevOut[i][j];
      end
      if (b !== expB) errs++;
    end
    chk(errs == 0, v.waitFlag ? "R10" : "R4", "capture buffer byte mismatches", errs, 0);
    dummy = firstErr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({tck, tms, tdi, busy, done, exitReached} === 6'b0, "R1", "outputs after reset",
        {tck, tms, tdi, busy, done, exitReached}, 0);
    for (int i = 0; i < NBYTES; i += 21) begin
      readByte(i, b);
      chk(b === 8'h00, "R1", "capture buffer after reset", b, 0);
    end
    // vector table
    for (int n = 0; n < NV; n++) runVec(VECS[n]);
    // directed: zero count gives no tck and immediate done (R9)
    riseBase = riseCnt;
    @(negedge clk);
    start = 1'b1; bitCount = 16'd0; mustEnd = 1'b0; waitMode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1, "R9", "zero-count wait done", done, 1);
    repeat (3) @(negedge clk);
    chk(riseCnt == riseBase, "R9", "zero-count tck rises", riseCnt - riseBase, 0);
    // directed: 9-bit transfer crossing a byte with one-bit tail (R3)
    runVec('{9, 1'b1, 1'b0, 11, 19, 1'b1});
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule